// File: doc/BRIEF.md
# Byte-Addressed Serial Memory Slave (two-wire bus)

This block is the slave side of a two-wire serial bus in front of a 2048-byte on-chip array. The SCL and SDA lines are oversampled in the system clock domain. The block finds bus start and stop conditions in the sampled lines and decodes the first byte of each transfer. The upper nibble of that byte is a fixed device code. The next three bits are not a chip select: they are the top three bits of the 11-bit memory address, so every value of them is accepted and merged with the word-address byte that follows.

In a write, the block takes a low address byte and then any number of data bytes. It stores each data byte and steps an internal address pointer by one. In a read, it returns bytes from the pointer, MSB first, for as long as the master acknowledges them. A repeated start lets a master set the address with a short write and then read from it. The block pulls SDA low only through an active-high output enable, so the pad is open-drain.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, and at all times when no transfer addressed to the block is in progress, sda_oe is low.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high, both judged on the synchronized lines. Bits clocked without a preceding START get no response. A STOP ends any transfer and releases SDA.
- R3: The first byte after a START arrives MSB first. It is acknowledged (sda_oe high through the 9th SCL high phase) only when its bits 7..4 equal 1010. Otherwise there is no acknowledge, and all later bytes get no acknowledge and no write until the next START.
- R4: Bits 3, 2 and 1 of an accepted first byte become pointer bits 10, 9 and 8 respectively. All eight values of these bits are acknowledged.
- R5: When bit 0 of the first byte is 0 (write), the next byte replaces pointer bits 7..0 and is acknowledged.
- R6: Each further byte of a write is stored at the pointer and acknowledged, and the pointer then increments by one modulo 2048.
- R7: When bit 0 of the first byte is 1 (read), the block drives out the byte at the pointer, MSB first, after the acknowledge. The pointer's top bits are the ones just received. sda_oe is high for each 0 bit.
- R8: If the master drives SDA low on the 9th clock of a read byte, the pointer increments modulo 2048 and the next byte follows. If SDA is high on that clock, the pointer is unchanged and nothing more is driven until the next START.
- R9: A repeated START at any point, including in the middle of a byte, drops the partial byte and restarts first-byte decoding. The pointer is kept, so an address-only write followed by a read returns data from that address.
- R10: A STOP in the middle of a data byte drops that byte without writing it.
- R11: sda_oe changes only in the cycle after a detected falling edge of SCL, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bound checker watches several rules on every cycle:
- SDA is never driven while the block is idle.
- A start or stop always takes the engine back to byte decoding or to idle, with SDA released.
- An accepted first byte is always acknowledged, and its three address bits land in the pointer.
- Each stored byte advances the pointer by exactly one, and the enable moves only after an SCL fall.

The data path itself can only be shown by the bench's bus scenarios. These cover writes that cross a page of the top bits and wrap past the last address, reads that run on under master acknowledges, and a read that starts at the pointer left by an earlier transfer. They also cover a foreign device code, and transfers cut short by a stop or a repeated start. A behavioural memory model sets the expected level on SDA for every clock of SCL high.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  // Transfer engine states
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a START
    ST_RX,     // shifting in a byte from the master
    ST_ACK,    // slave holds SDA low for the 9th clock
    ST_TX,     // shifting out a read byte
    ST_MACK    // master acknowledge slot of a read byte
  } slv_state_e;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    K_DEV,     // first byte: device code, high address bits, direction
    K_WADDR,   // low word-address byte
    K_DATA     // write data
  } rx_kind_e;

endpackage

// File: rtl/i2c_bus_cond.sv
// Synchronizes SCL/SDA into clk and derives edges and bus conditions.
module i2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sr, sda_sr;
  logic         scl_d, sda_d;
  logic         scl_lvl;

  // Idle bus level is high on both lines, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[MSB-1:0], scl_i};
      sda_sr <= {sda_sr[MSB-1:0], sda_i};
      scl_d  <= scl_sr[MSB];
      sda_d  <= sda_sr[MSB];
    end
  end

  assign scl_lvl   = scl_sr[MSB];
  assign sda_lvl   = sda_sr[MSB];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // SDA moving while SCL stays high is a bus condition, never data
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_byte_ram.sv
// Byte array: one synchronous write port, one asynchronous read port.
module i2c_byte_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         AW          = 11,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_mem_pkg::*;

  // Address bits carried by the first byte
  localparam int HI_W = AW - 8;

  // ---- arithmetic kept in functions ----
  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return p + 1'b1;  // wraps modulo 2**AW
  endfunction

  function automatic logic [AW-1:0] ptr_with_hi(input logic [AW-1:0] p,
                                                input logic [HI_W-1:0] hi);
    return {hi, p[7:0]};
  endfunction

  function automatic logic [AW-1:0] ptr_with_lo(input logic [AW-1:0] p,
                                                input logic [7:0] lo);
    return {p[AW-1:8], lo};
  endfunction

  function automatic logic code_hit(input logic [7:0] b);
    return b[7:4] == DEV_CODE;
  endfunction

  // ---- bus front end ----
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // ---- engine state ----
  slv_state_e    state_q;
  rx_kind_e      kind_q;
  logic [2:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          rx_full;
  logic          rw_q;
  logic          mack_q;
  logic          oe_q;
  logic [AW-1:0] ptr;
  logic [7:0]    rd_data;

  // ---- named internal events ----
  logic byte_evt, dev_eval, dev_match, wr_en;
  assign byte_evt  = (state_q == ST_RX) && rx_full && scl_fall;
  assign dev_eval  = byte_evt && (kind_q == K_DEV);
  assign dev_match = code_hit(shreg);
  assign wr_en     = byte_evt && (kind_q == K_DATA);

  i2c_byte_ram #(.AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (ptr),
    .wdata (shreg),
    .raddr (ptr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      rx_full <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      ptr     <= '0;
    end else if (start_det) begin
      // START or repeated START: drop any partial byte, decode afresh
      state_q <= ST_RX;
      kind_q  <= K_DEV;
      bit_cnt <= '0;
      rx_full <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      rx_full <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && !rx_full) begin
            shreg   <= {shreg[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) rx_full <= 1'b1;
          end else if (byte_evt) begin
            rx_full <= 1'b0;
            bit_cnt <= '0;
            case (kind_q)
              K_DEV: begin
                if (dev_match) begin
                  ptr     <= ptr_with_hi(ptr, shreg[HI_W:1]);
                  rw_q    <= shreg[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              K_WADDR: begin
                ptr     <= ptr_with_lo(ptr, shreg);
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
              end
              default: begin  // K_DATA: array written through wr_en
                ptr     <= ptr_next(ptr);
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
              end
            endcase
          end
        end

        ST_ACK: begin
          if (scl_fall) begin
            if (rw_q && kind_q == K_DEV) begin
              shreg   <= rd_data;
              oe_q    <= ~rd_data[7];
              bit_cnt <= '0;
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              kind_q  <= (kind_q == K_DEV) ? K_WADDR : K_DATA;
              state_q <= ST_RX;
            end
          end
        end

        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              oe_q    <= 1'b0;
              mack_q  <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              shreg   <= {shreg[6:0], 1'b0};
              oe_q    <= ~shreg[6];
            end
          end
        end

        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
            if (!sda_lvl) ptr <= ptr_next(ptr);
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg   <= rd_data;
              oe_q    <= ~rd_data[7];
              bit_cnt <= '0;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end

        default: ;  // ST_IDLE: bus activity ignored until START
      endcase
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/i2c_mem_chk.sv
module i2c_mem_chk #(
  parameter int AW = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sda_oe,
  input logic                    scl_fall,
  input logic                    start_det,
  input logic                    stop_det,
  input logic                    dev_eval,
  input logic                    dev_match,
  input logic                    wr_en,
  input i2c_mem_pkg::slv_state_e state,
  input logic [AW-1:0]           ptr,
  input logic [7:0]              shreg
);
  import i2c_mem_pkg::*;
  localparam int HI_W = AW - 8;

  assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_oe);

  assert_foreign_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_eval && !dev_match) |=> (state == ST_IDLE) && !sda_oe);

  assert_match_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_eval && dev_match) |=> sda_oe);

  assert_hi_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_eval && dev_match) |=> ptr[AW-1:8] == $past(shreg[HI_W:1]));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == AW'($past(ptr) + 1'b1));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX) && !sda_oe);

  assert_oe_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall));

endmodule

bind i2c_mem_slave i2c_mem_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .dev_eval  (dev_eval),
  .dev_match (dev_match),
  .wr_en     (wr_en),
  .state     (state_q),
  .ptr       (ptr),
  .shreg     (shreg)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int Q     = 12;      // clk cycles per quarter of an SCL bit
  localparam int MSIZE = 2048;
  localparam int WDOG  = 150000;

  logic  clk = 1'b0, rst_n = 1'b0;
  logic  scl_m = 1'b1, sda_m = 1'b1;
  logic  exp_oe = 1'b0, chk_en = 1'b0;
  logic  sda_oe;
  wire   sda_line = sda_m & ~sda_oe;   // wired-AND open-drain bus
  int    n_cmp = 0, n_fail = 0;
  string cur_req = "R1";

  // behavioural reference: byte array and pointer
  logic [7:0] mdl_mem [MSIZE];
  int         mdl_ptr = 0;

  always #5 clk = ~clk;  // 100 MHz with 1 ns units

  i2c_mem_slave i_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe));

  // per-clock comparison of the drive against the model during SCL high
  always @(posedge clk) begin
    if (chk_en) begin
      #2;
      n_cmp++;
      if (sda_oe !== exp_oe) begin
        n_fail++;
        $display("FAIL %s: sda_oe actual=%0b expected=%0b at %0t", cur_req, sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL bit: master level mbit, expected slave drive while SCL is high
  task automatic clk_bit(input logic mbit, input logic drv, output logic line);
    sda_m = mbit;   wait_n(Q);
    scl_m = 1'b1;   wait_n(4);
    exp_oe = drv; chk_en = 1'b1; wait_n(4);
    line = sda_line; chk_en = 1'b0; wait_n(Q - 8);
    scl_m = 1'b0;   wait_n(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    logic l;
    for (int i = 7; i > 7 - nb; i--) clk_bit(b[i], 1'b0, l);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack);
    logic l;
    send_bits(b, 8);
    clk_bit(1'b1, exp_ack, l);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack);
    logic [7:0] got;
    logic l;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~exp[i], l);
      got[i] = l;
    end
    clk_bit(~mack, 1'b0, l);
    check(cur_req, {24'd0, got}, {24'd0, exp});
  endtask

  function automatic int with_hi(input int p, input int hi);
    return (hi * 256) + (p % 256);
  endfunction

  task automatic write_txn(input int hi, input int lo, input int n, input int seed);
    bus_start();
    send_byte({4'hA, 3'(hi), 1'b0}, 1'b1);
    mdl_ptr = with_hi(mdl_ptr, hi);
    send_byte(8'(lo), 1'b1);
    mdl_ptr = (mdl_ptr / 256) * 256 + lo;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(seed + 37 * k);
      send_byte(d, 1'b1);
      mdl_mem[mdl_ptr] = d;
      mdl_ptr = (mdl_ptr + 1) % MSIZE;
    end
    bus_stop();
  endtask

  // set_addr: address-only write then repeated START before the read
  task automatic read_txn(input int hi, input logic set_addr, input int lo, input int n);
    if (set_addr) begin
      bus_start();
      send_byte({4'hA, 3'(hi), 1'b0}, 1'b1);
      mdl_ptr = with_hi(mdl_ptr, hi);
      send_byte(8'(lo), 1'b1);
      mdl_ptr = (mdl_ptr / 256) * 256 + lo;
    end
    bus_start();
    send_byte({4'hA, 3'(hi), 1'b1}, 1'b1);
    mdl_ptr = with_hi(mdl_ptr, hi);
    for (int k = 0; k < n; k++) begin
      recv_byte(mdl_mem[mdl_ptr], k < n - 1);
      if (k < n - 1) mdl_ptr = (mdl_ptr + 1) % MSIZE;
    end
    bus_stop();
  endtask

  initial begin
    for (int a = 0; a < MSIZE; a++) mdl_mem[a] = 8'h00;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    check("R1", {31'd0, sda_oe}, 32'd0);

    // R2: bits clocked with no START get no acknowledge
    cur_req = "R2";
    scl_m = 1'b0; wait_n(Q);
    send_byte(8'hA0, 1'b0);
    bus_stop();

    // R4 R5 R6: write crossing from high bits 3 into high bits 4
    cur_req = "R6";
    write_txn(3, 8'hFC, 6, 8'h11);

    // R7 R8 R9: address-only write, repeated START, sequential read
    cur_req = "R8";
    read_txn(3, 1'b1, 8'hFD, 5);

    // R7: read from the pointer left by the last transfer (0x401)
    cur_req = "R7";
    read_txn(4, 1'b0, 0, 1);

    // R6 R8: write and read wrapping past the last address
    cur_req = "R6";
    write_txn(7, 8'hFE, 3, 8'hC3);
    cur_req = "R8";
    read_txn(7, 1'b1, 8'hFE, 3);

    // R3: foreign device code, later bytes ignored, array untouched
    cur_req = "R3";
    bus_start();
    send_byte(8'hB0, 1'b0);
    send_byte(8'h00, 1'b0);
    send_byte(8'h55, 1'b0);
    bus_stop();
    read_txn(0, 1'b1, 0, 1);

    // R10: STOP inside a data byte leaves 0x7FE unchanged
    cur_req = "R10";
    bus_start();
    send_byte({4'hA, 3'd7, 1'b0}, 1'b1);
    send_byte(8'hFE, 1'b1);
    mdl_ptr = 16'h7FE;
    send_bits(8'h12, 4);
    bus_stop();
    read_txn(7, 1'b0, 0, 1);

    // R9: repeated START inside a data byte, then read 0x000
    cur_req = "R9";
    bus_start();
    send_byte({4'hA, 3'd0, 1'b0}, 1'b1);
    send_byte(8'h00, 1'b1);
    mdl_ptr = 0;
    send_bits(8'hEE, 5);
    read_txn(0, 1'b0, 0, 1);

    // R4: every high-bit value is acknowledged
    cur_req = "R4";
    for (int h = 0; h < 8; h++) begin
      bus_start();
      send_byte({4'hA, 3'(h), 1'b0}, 1'b1);
      mdl_ptr = with_hi(mdl_ptr, h);
      bus_stop();
    end
    wait_n(Q);
    check("R1", {31'd0, sda_oe}, 32'd0);

    summary();
  end

endmodule